// File: doc/BRIEF.md
# Translation Unit Control and Fault Registers

This block is the software-visible control surface of a small two-level address translation unit. A 32-bit word-addressed register bus writes and reads a control word, a page-table base, an address cap, a shootdown word, a bypass window, a miscellaneous word and the page that illegal accesses are redirected to. These registers drive the translation datapath directly. The block also holds saturating hit, miss and stall counters, a captured violation address and a read-only configuration word.

The translation datapath reports three kinds of fault as one-cycle pulses: write violation, invalid table entry and capacity exceeded. Each fault has a sticky flag in the control word and its own abort, interrupt and exception enables. Software clears a flag by writing 1 to it. In the same write it can start a full TLB clear, which sends a one-cycle request to the TLB and raises a busy bit for a fixed time, and it can zero the statistics counters.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset, every register reads 0 except the configuration word. All outputs are low.
- R2: The control word stores bit 0 (translate enable), bit 1 (count enable), bit 8 (global bypass), bit 16 (invalid-entry check enable) and the nine fault enable bits 9-11, 17-19 and 24-26. The command bits 2 and 3 and every unlisted bit read 0. Bits 0, 8 and 16 drive `xlate_en_o`, `bypass_o` and `inval_chk_o`.
- R3: Writing 1 to control bit 2 makes `tlb_clr_o` high for exactly the next cycle. Control bit 7 then reads 1 for CLR_CYCLES cycles and 0 afterwards. A new request while busy restarts the count.
- R4: While control bit 1 is set, the counter at word offset 0x08 (hit, `ev_i[0]`), 0x0C (miss, `ev_i[1]`) or 0x10 (stall, `ev_i[2]`) increments once per cycle its event is high. It saturates at its maximum. With bit 1 clear, the counters hold.
- R5: Writing 1 to control bit 3 zeroes all three counters. This takes priority over an event in the same cycle.
- R6: Writes to the counters, the violation address (0x34) and the configuration word (0x38) have no effect. The configuration word holds version in bits 3:0, VA width code in 7:4, PA width code in 11:8, big-page width in 19:12, super-page width in 27:20, 4 MB bypass granularity in bit 28 and bypass support in bit 29.
- R7: A pulse on `flt_i[0]` (write violation), `flt_i[1]` (invalid entry) or `flt_i[2]` (capacity) sets control bit 12, 20 or 27 respectively. The bit stays set until cleared.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A fault in the same cycle wins over the clear. A single write may clear flags, start a TLB clear and clear the statistics together.
- R9: While control bit 16 is 0, `flt_i[1]` sets no flag, raises no abort and captures no address.
- R10: The violation address register captures `flt_addr_i` on a fault when no flag is set. It holds its value while any flag is set.
- R11: `irq_o` is the OR over faults of flag AND interrupt enable (bits 10, 18, 25). `exc_o[k]` is flag AND exception enable (bits 9, 17, 24).
- R12: `abort_o[k]` is high in the same cycle as the accepted fault pulse when the abort enable (bits 11, 19, 26) is set.
- R13: Word offsets 0x04, 0x14, 0x18, 0x1C, 0x20, 0x24 and 0x30 are full 32-bit read/write registers. Each drives its own output. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| ev_i | input | 3 | Hit, miss, stall event pulses |
| flt_i | input | 3 | Write violation, invalid entry, capacity fault pulses |
| flt_addr_i | input | 32 | Virtual address of the faulting access |
| xlate_en_o | output | 1 | Translation enable |
| bypass_o | output | 1 | Global bypass |
| inval_chk_o | output | 1 | Invalid-entry checking enable |
| tlb_clr_o | output | 1 | One-cycle full TLB clear request |
| abort_o | output | 3 | Per-fault abort for the faulting access |
| exc_o | output | 3 | Per-fault exception level |
| irq_o | output | 1 | Combined fault interrupt |
| pt_base_o | output | 32 | Page-table base (0x04) |
| cap_o | output | 32 | Address cap (0x14) |
| shoot_o | output | 32 | Shootdown word (0x18) |
| byp_lo_o | output | 32 | Bypass window start (0x1C) |
| byp_hi_o | output | 32 | Bypass window end (0x20) |
| misc_o | output | 32 | Miscellaneous word (0x24) |
| illeg_o | output | 32 | Illegal-address redirect page (0x30) |

## Verification
The bench sends the counters a continuous event stream to tell saturation apart from wrap-around. An alternating stream shows that every event is counted once. A stream with counting disabled shows that the counters hold. Single-fault pulses tell the three flags and their enable bits apart. Two faults in a row separate first-fault capture from overwrite. A fault that coincides with its own write-one-to-clear shows which of the two takes priority. The combined clear-and-command write, and a TLB clear issued again while busy, check the sequencer's restart. Invalid-entry pulses with checking turned off show that the gate blocks the flag, the abort and the address capture.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
   localparam int NFLT   = 3;
   localparam int NEV    = 3;
   localparam int NPLAIN = 7;

   // fault lane index
   localparam int F_WRV = 0;
   localparam int F_INV = 1;
   localparam int F_CAP = 2;

   // control word bit positions
   localparam int C_EN     = 0;
   localparam int C_STAT   = 1;
   localparam int C_TLBCLR = 2;
   localparam int C_STCLR  = 3;
   localparam int C_BUSY   = 7;
   localparam int C_BYP    = 8;
   localparam int C_INVCHK = 16;
   localparam logic [31:0] CTRL_RW = 32'h070F_0F03;

   // flag position per lane; abort, irq, exception enables sit 1, 2, 3 below
   localparam int FLAG_POS [NFLT] = '{12, 20, 27};

   // word indexes (byte offset / 4)
   localparam int W_CTRL = 0;
   localparam int W_VIOL = 13;
   localparam int W_INFO = 14;
   localparam int CNT_WIDX   [NEV]    = '{2, 3, 4};
   localparam int PLAIN_WIDX [NPLAIN] = '{1, 5, 6, 7, 8, 9, 12};
endpackage

// File: rtl/mmu_flt_lane.sv
module mmu_flt_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic w1c,
   input  logic en_abort,
   input  logic en_irq,
   input  logic en_exc,
   output logic flag,
   output logic abort,
   output logic irq,
   output logic exc
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (ev)  flag_q <= 1'b1;
      else if (w1c) flag_q <= 1'b0;
   end

   assign flag  = flag_q;
   assign abort = ev & en_abort;
   assign irq   = flag_q & en_irq;
   assign exc   = flag_q & en_exc;
endmodule

// File: rtl/mmu_stat_ctr.sv
module mmu_stat_ctr #(
   parameter int W   = 32,
   parameter int SAT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] nxt;

   generate
      if (SAT != 0) begin : g_sat
         assign nxt = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign nxt = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= nxt;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/mmu_clr_seq.sv
module mmu_clr_seq #(
   parameter int CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pulse,
   output logic busy
);
   localparam int CW = $clog2(CYC + 1);
   logic [CW-1:0] left_q;
   logic          pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q  <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= start;
         if (start)              left_q <= CW'(CYC);
         else if (left_q != '0)  left_q <= left_q - 1'b1;
      end
   end

   assign pulse = pulse_q;
   assign busy  = (left_q != '0);
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs import mmu_ctl_pkg::*; #(
   parameter int ADDR_W     = 6,
   parameter int CNT_W      = 32,
   parameter int CLR_CYCLES = 8,
   parameter int SATURATE   = 1,
   parameter int HW_VERSION = 4,
   parameter int VA_CODE    = 6,
   parameter int PA_CODE    = 6,
   parameter int BIG_W      = 4,
   parameter int SUPER_W    = 8,
   parameter int BYP_4M     = 1,
   parameter int BYP_OK     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NEV-1:0]    ev_i,
   input  logic [NFLT-1:0]   flt_i,
   input  logic [31:0]       flt_addr_i,
   output logic              xlate_en_o,
   output logic              bypass_o,
   output logic              inval_chk_o,
   output logic              tlb_clr_o,
   output logic [NFLT-1:0]   abort_o,
   output logic [NFLT-1:0]   exc_o,
   output logic              irq_o,
   output logic [31:0]       pt_base_o,
   output logic [31:0]       cap_o,
   output logic [31:0]       shoot_o,
   output logic [31:0]       byp_lo_o,
   output logic [31:0]       byp_hi_o,
   output logic [31:0]       misc_o,
   output logic [31:0]       illeg_o
);
   localparam int WIDX_W = ADDR_W - 2;
   localparam logic [31:0] INFO = {2'b00, 1'(BYP_OK), 1'(BYP_4M), 8'(SUPER_W),
                                   8'(BIG_W), 4'(PA_CODE), 4'(VA_CODE), 4'(HW_VERSION)};

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x38");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must be 1..32");
      end
      if (CLR_CYCLES < 1) begin : g_bad_clr
         $error("CLR_CYCLES must be at least 1");
      end
   endgenerate

   logic [WIDX_W-1:0] widx;
   logic              addr_lsb_unused;
   logic              ctrl_wr;
   logic [31:0]       ctrl_q;
   logic [31:0]       viol_q;
   logic [31:0]       plain_q [NPLAIN];
   logic [CNT_W-1:0]  cnt     [NEV];
   logic [NFLT-1:0]   flag;
   logic [NFLT-1:0]   flt_ok;
   logic [NFLT-1:0]   irq_v;
   logic              clr_busy;
   logic [31:0]       rd_ctrl;

   assign widx            = reg_addr[ADDR_W-1:2];
   assign addr_lsb_unused = ^reg_addr[1:0];
   assign ctrl_wr         = reg_wen && (widx == WIDX_W'(W_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_RW;
   end

   // plain read/write registers
   generate
      for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n) plain_q[g] <= '0;
            else if (reg_wen && widx == WIDX_W'(PLAIN_WIDX[g])) plain_q[g] <= reg_wdata;
         end
      end
   endgenerate

   assign pt_base_o = plain_q[0];
   assign cap_o     = plain_q[1];
   assign shoot_o   = plain_q[2];
   assign byp_lo_o  = plain_q[3];
   assign byp_hi_o  = plain_q[4];
   assign misc_o    = plain_q[5];
   assign illeg_o   = plain_q[6];

   assign xlate_en_o  = ctrl_q[C_EN];
   assign bypass_o    = ctrl_q[C_BYP];
   assign inval_chk_o = ctrl_q[C_INVCHK];

   // fault lanes
   generate
      for (genvar k = 0; k < NFLT; k++) begin : g_lane
         localparam int FP = FLAG_POS[k];
         if (k == F_INV) begin : g_gated
            assign flt_ok[k] = flt_i[k] & ctrl_q[C_INVCHK];
         end else begin : g_open
            assign flt_ok[k] = flt_i[k];
         end
         mmu_flt_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (flt_ok[k]),
            .w1c      (ctrl_wr && reg_wdata[FP]),
            .en_abort (ctrl_q[FP-1]),
            .en_irq   (ctrl_q[FP-2]),
            .en_exc   (ctrl_q[FP-3]),
            .flag     (flag[k]),
            .abort    (abort_o[k]),
            .irq      (irq_v[k]),
            .exc      (exc_o[k])
         );
      end
   endgenerate

   assign irq_o = |irq_v;

   always_ff @(posedge clk) begin
      if (!rst_n)                     viol_q <= '0;
      else if ((|flt_ok) && !(|flag)) viol_q <= flt_addr_i;
   end

   // statistics counters
   generate
      for (genvar k = 0; k < NEV; k++) begin : g_ctr
         mmu_stat_ctr #(.W(CNT_W), .SAT(SATURATE)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ctrl_wr && reg_wdata[C_STCLR]),
            .inc   (ctrl_q[C_STAT] && ev_i[k]),
            .cnt   (cnt[k])
         );
      end
   endgenerate

   mmu_clr_seq #(.CYC(CLR_CYCLES)) u_clr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ctrl_wr && reg_wdata[C_TLBCLR]),
      .pulse (tlb_clr_o),
      .busy  (clr_busy)
   );

   // read path
   always_comb begin
      rd_ctrl         = ctrl_q;
      rd_ctrl[C_BUSY] = clr_busy;
      for (int k = 0; k < NFLT; k++) rd_ctrl[FLAG_POS[k]] = flag[k];
   end

   always_comb begin
      reg_rdata = '0;
      if (widx == WIDX_W'(W_CTRL)) reg_rdata = rd_ctrl;
      if (widx == WIDX_W'(W_VIOL)) reg_rdata = viol_q;
      if (widx == WIDX_W'(W_INFO)) reg_rdata = INFO;
      for (int g = 0; g < NPLAIN; g++)
         if (widx == WIDX_W'(PLAIN_WIDX[g])) reg_rdata = plain_q[g];
      for (int k = 0; k < NEV; k++)
         if (widx == WIDX_W'(CNT_WIDX[k])) reg_rdata = 32'(cnt[k]);
   end
endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk import mmu_ctl_pkg::*; (
   input logic            clk,
   input logic            rst_n,
   input logic            ctrl_wr,
   input logic [31:0]     reg_wdata,
   input logic [NFLT-1:0] flt_i,
   input logic [NFLT-1:0] abort_o,
   input logic            tlb_clr_o,
   input logic            irq_o,
   input logic [NFLT-1:0] flag,
   input logic            clr_busy,
   input logic [31:0]     viol_q,
   input logic [31:0]     ctrl_q
);
   assert_clr_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && reg_wdata[C_TLBCLR] |=> tlb_clr_o && clr_busy);

   assert_abort_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_o & ~flt_i) == '0);

   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|flag));

   assert_viol_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag) |=> $stable(viol_q));

   assert_inval_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[C_INVCHK] && !flag[F_INV] |=> !flag[F_INV]);

   generate
      for (genvar k = 0; k < NFLT; k++) begin : g_sticky
         assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            flag[k] |=> flag[k] || $past(ctrl_wr && reg_wdata[FLAG_POS[k]]));
      end
   endgenerate
endmodule

bind mmu_ctl_regs mmu_ctl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_wr   (ctrl_wr),
   .reg_wdata (reg_wdata),
   .flt_i     (flt_i),
   .abort_o   (abort_o),
   .tlb_clr_o (tlb_clr_o),
   .irq_o     (irq_o),
   .flag      (flag),
   .clr_busy  (clr_busy),
   .viol_q    (viol_q),
   .ctrl_q    (ctrl_q)
);

// File: tb/sim_mmu_ctl_regs.sv
`timescale 1ns/1ps
module sim_mmu_ctl_regs;
   localparam int CNTW = 4;
   localparam int CMAX = 15;
   localparam int CLRN = 5;
   localparam logic [31:0] M_INFO = (32'd1 << 29) | (32'd1 << 28) | (32'd8 << 20) |
                                    (32'd4 << 12) | (32'd6 << 8) | (32'd6 << 4) | 32'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wen = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [2:0]  ev = '0;
   logic [2:0]  flt = '0;
   logic [31:0] faddr = '0;
   logic [31:0] rdata;
   logic        xlate_en, bypass, inval_chk, tlb_clr, irq;
   logic [2:0]  abort, exc;
   logic [31:0] pt_base, cap, shoot, byp_lo, byp_hi, misc, illeg;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   mmu_ctl_regs #(.CNT_W(CNTW), .CLR_CYCLES(CLRN)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wen(wen), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .ev_i(ev), .flt_i(flt), .flt_addr_i(faddr),
      .xlate_en_o(xlate_en), .bypass_o(bypass), .inval_chk_o(inval_chk),
      .tlb_clr_o(tlb_clr), .abort_o(abort), .exc_o(exc), .irq_o(irq),
      .pt_base_o(pt_base), .cap_o(cap), .shoot_o(shoot), .byp_lo_o(byp_lo),
      .byp_hi_o(byp_hi), .misc_o(misc), .illeg_o(illeg));

   // reference model
   logic [31:0] m_ctrl, m_viol;
   logic [31:0] m_plain [16];
   logic [2:0]  m_flag;
   int          m_cnt [3];
   int          m_busy;
   logic        m_pulse;

   function automatic int fpos(int k);
      return (k == 0) ? 12 : (k == 1) ? 20 : 27;
   endfunction

   function automatic logic [2:0] gated(logic [2:0] f);
      logic [2:0] q = f;
      if (!m_ctrl[16]) q[1] = 1'b0;
      return q;
   endfunction

   function automatic logic [31:0] exp_rd(int w);
      logic [31:0] v;
      case (w)
         0: begin
            v = m_ctrl;
            for (int k = 0; k < 3; k++) v[fpos(k)] = m_flag[k];
            v[7] = (m_busy > 0);
         end
         2, 3, 4: v = 32'(m_cnt[w-2]);
         13: v = m_viol;
         14: v = M_INFO;
         default: v = m_plain[w];
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_viol = '0; m_flag = '0; m_busy = 0; m_pulse = 1'b0;
         for (int i = 0; i < 16; i++) m_plain[i] = '0;
         for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      end else begin
         logic [2:0] q;
         logic       cw;
         int         w;
         w  = int'(addr >> 2);
         cw = wen && (w == 0);
         q  = gated(flt);
         if (q != 0 && m_flag == 0) m_viol = faddr;
         for (int k = 0; k < 3; k++) begin
            if (q[k]) m_flag[k] = 1'b1;
            else if (cw && wdata[fpos(k)]) m_flag[k] = 1'b0;
         end
         for (int k = 0; k < 3; k++) begin
            if (cw && wdata[3]) m_cnt[k] = 0;
            else if (m_ctrl[1] && ev[k] && m_cnt[k] < CMAX) m_cnt[k]++;
         end
         m_pulse = cw && wdata[2];
         if (cw && wdata[2]) m_busy = CLRN;
         else if (m_busy > 0) m_busy--;
         if (wen && (w == 1 || w == 5 || w == 6 || w == 7 || w == 8 || w == 9 || w == 12))
            m_plain[w] = wdata;
         if (cw) m_ctrl = wdata & 32'h070F_0F03;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // compare against the model every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] q;
         q = gated(flt);
         chk(cur_req, "rdata", rdata, exp_rd(int'(addr >> 2)));
         chk("R2", "ctrl outs", {29'd0, xlate_en, bypass, inval_chk},
             {29'd0, m_ctrl[0], m_ctrl[8], m_ctrl[16]});
         chk("R3", "tlb_clr", {31'd0, tlb_clr}, {31'd0, m_pulse});
         chk("R12", "abort", {29'd0, abort}, {29'd0, q & {m_ctrl[26], m_ctrl[19], m_ctrl[11]}});
         chk("R11", "exc", {29'd0, exc}, {29'd0, m_flag & {m_ctrl[24], m_ctrl[17], m_ctrl[9]}});
         chk("R11", "irq", {31'd0, irq}, {31'd0, |(m_flag & {m_ctrl[25], m_ctrl[18], m_ctrl[10]})});
         chk("R13", "pt_base", pt_base, m_plain[1]);
         chk("R13", "cap", cap, m_plain[5]);
         chk("R13", "shoot", shoot, m_plain[6]);
         chk("R13", "byp_lo", byp_lo, m_plain[7]);
         chk("R13", "byp_hi", byp_hi, m_plain[8]);
         chk("R13", "misc", misc, m_plain[9]);
         chk("R13", "illeg", illeg, m_plain[12]);
      end
   end

   task automatic cy(input logic w, input int a, input logic [31:0] d,
                     input logic [2:0] e, input logic [2:0] f, input logic [31:0] fa);
      @(posedge clk); #1;
      wen = w; addr = 6'(a); wdata = d; ev = e; flt = f; faddr = fa;
   endtask

   task automatic idle(input int a);
      cy(1'b0, a, '0, '0, '0, '0);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      cy(1'b1, a, d, '0, '0, '0);
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      idle(a);
      @(negedge clk);
      chk(req, "direct read", rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state of every word
      cur_req = "R1";
      for (int w = 0; w < 16; w++) idle(w * 4);
      rd_chk("R1", 'h00, 32'h0);
      rd_chk("R1", 'h08, 32'h0);
      rd_chk("R6", 'h38, 32'h3080_4664);

      // R13: plain registers and unmapped words
      cur_req = "R13";
      wr('h04, 32'hA5A5_0001); wr('h14, 32'h0000_0A7F); wr('h18, 32'h4000_0010);
      wr('h1C, 32'h8000_0000); wr('h20, 32'h8000_000A); wr('h24, 32'h7FFF_FFFF);
      wr('h30, 32'hDEAD_B000);
      rd_chk("R13", 'h30, 32'hDEAD_B000);
      rd_chk("R13", 'h04, 32'hA5A5_0001);
      wr('h28, 32'hFFFF_FFFF); wr('h3C, 32'h1234_5678);
      rd_chk("R13", 'h28, 32'h0);
      rd_chk("R13", 'h3C, 32'h0);

      // R2: control field storage
      cur_req = "R2";
      wr('h00, 32'hFFFF_FFF3);
      rd_chk("R2", 'h00, 32'h070F_0F03);
      chk("R2", "xlate_en", {31'd0, xlate_en}, 32'd1);
      wr('h00, 32'h0000_0002);

      // R4: counting, saturation, disabled hold
      cur_req = "R4";
      for (int i = 0; i < 20; i++) cy(1'b0, 'h08, '0, 3'b001, '0, '0);
      rd_chk("R4", 'h08, 32'd15);
      for (int i = 0; i < 6; i++) cy(1'b0, 'h0C, '0, (i % 2 == 0) ? 3'b010 : 3'b000, '0, '0);
      rd_chk("R4", 'h0C, 32'd3);
      wr('h00, 32'h0);
      for (int i = 0; i < 4; i++) cy(1'b0, 'h10, '0, 3'b100, '0, '0);
      rd_chk("R4", 'h10, 32'd0);

      // R5: statistics clear wins over events
      cur_req = "R5";
      wr('h00, 32'h0000_0002);
      cy(1'b0, 'h08, '0, 3'b111, '0, '0);
      cy(1'b1, 'h00, 32'h0000_000A, 3'b111, '0, '0);
      rd_chk("R5", 'h08, 32'd0);
      cy(1'b0, 'h0C, '0, 3'b111, '0, '0);
      cy(1'b0, 'h0C, '0, 3'b111, '0, '0);
      rd_chk("R5", 'h0C, 32'd2);

      // R6: read-only words ignore writes
      cur_req = "R6";
      wr('h08, 32'hFFFF_FFFF);
      rd_chk("R6", 'h08, 32'd2);
      wr('h38, 32'h0);
      rd_chk("R6", 'h38, 32'h3080_4664);
      wr('h34, 32'h1234_0000);
      rd_chk("R6", 'h34, 32'h0);

      // R3: TLB clear pulse and busy window
      cur_req = "R3";
      wr('h00, 32'h0000_0004);
      idle('h00);
      @(negedge clk);
      chk("R3", "pulse", {31'd0, tlb_clr}, 32'd1);
      chk("R3", "busy first", rdata, 32'h0000_0080);
      for (int i = 0; i < CLRN - 1; i++) begin
         idle('h00);
         @(negedge clk);
         chk("R3", "busy held", rdata, 32'h0000_0080);
         chk("R3", "pulse once", {31'd0, tlb_clr}, 32'd0);
      end
      rd_chk("R3", 'h00, 32'h0);
      wr('h00, 32'h4); idle('h00); idle('h00); wr('h00, 32'h4);
      for (int i = 0; i < 7; i++) idle('h00);

      // R7, R11, R12, R10: faults with all enables on
      cur_req = "R7";
      wr('h00, 32'h070F_0E01);
      cy(1'b0, 'h00, '0, '0, 3'b001, 32'h1000_0040);
      @(negedge clk);
      chk("R12", "abort wrv", {29'd0, abort}, 32'd1);
      rd_chk("R7", 'h00, 32'h070F_1E01);
      chk("R11", "irq", {31'd0, irq}, 32'd1);
      chk("R11", "exc", {29'd0, exc}, 32'd1);
      rd_chk("R10", 'h34, 32'h1000_0040);
      cur_req = "R10";
      cy(1'b0, 'h34, '0, '0, 3'b100, 32'h2000_0080);
      rd_chk("R10", 'h34, 32'h1000_0040);

      // R8: set wins, write-one-to-clear, combined commands
      cur_req = "R8";
      cy(1'b1, 'h00, 32'h070F_0E01 | 32'h0810_0000, '0, 3'b100, 32'h2000_00C0);
      rd_chk("R8", 'h00, 32'h0F0F_1E01);
      wr('h00, 32'h0F1F_1E0D);
      rd_chk("R8", 'h00, 32'h070F_0E81);
      chk("R8", "irq cleared", {31'd0, irq}, 32'd0);
      cy(1'b0, 'h34, '0, '0, 3'b010, 32'h3000_0100);
      rd_chk("R10", 'h34, 32'h3000_0100);

      // R9: invalid-entry gate off
      cur_req = "R9";
      for (int i = 0; i < 6; i++) idle('h00);
      wr('h00, 32'h070E_0E01 | 32'h0010_0000);
      idle('h00);
      cy(1'b0, 'h00, '0, '0, 3'b010, 32'h4000_0000);
      @(negedge clk);
      chk("R9", "no abort", {29'd0, abort}, 32'd0);
      rd_chk("R9", 'h00, 32'h070E_0E01);
      rd_chk("R9", 'h34, 32'h3000_0100);

      idle('h00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule